// File: doc/BRIEF.md
# Fractional clock divider bank

This block holds eight programmable rate generators that share one input clock. Each channel divides the input rate by a fixed-point divisor with five fractional bits. The output frequency is the input frequency times 32 divided by the stored value. Each channel has a phase accumulator. The accumulator grows by 64 on every enabled input cycle. When the next sum reaches the active divisor, the accumulator keeps the remainder and the channel's square-wave output changes level. The remainder is kept, so the long-run rate is exact and edges fall on the nearest input cycle.

Software programs the bank through a small word-addressed register port with a byte address, write data, write strobe and registered read data. A channel runs only when its own enable bit and the shared master bit are both set. A stored divisor of zero selects pass-through, where the channel ticks on every input cycle. All outputs are synchronous levels and strobes in the input clock domain. The register port is control-only, so it has no valid/ready handshake.

Top module: `frac_clk_bank`

## Requirements
- R1: Word offset n (byte address 4·n, n = 0..7) holds the divisor of channel n in bits 17:0. Every divisor resets to 0x3FFC0, and the address bits 1:0 are ignored.
- R2: A read returns, one cycle after the address is presented, the divisor in bits 17:0 with zeros above. The control word at byte 0x20 returns channel enables in bits 7:0 and the master enable in bit 31, with zeros elsewhere. Byte addresses 0x24 to 0x3C read as zero, and writes to them change nothing.
- R3: With active divisor d ≥ 64, a channel that starts from its cleared state makes exactly floor(64·N/d) level changes on `chan_phase` over its first N enabled cycles, so its square wave runs at input·32/d.
- R4: With active divisor 0 (pass-through), an enabled channel raises `chan_tick` on every cycle, and `chan_phase` changes level on every cycle.
- R5: A channel runs only while both its control bit n and control bit 31 are 1. Otherwise its outputs stay 0.
- R6: A stopped channel clears its accumulator and holds `chan_phase` and `chan_tick` low. After it is enabled, its first level change comes exactly ceil(d/64) cycles after the enabling write.
- R7: A divisor written while a channel runs becomes active only at that channel's next level change. A channel's active divisor never changes on a cycle without a level change.
- R8: For d ≥ 64, `chan_tick` is high for exactly the one cycle in which `chan_phase` has just risen from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| chan_phase | output | 8 | Per-channel divided square wave |
| chan_tick | output | 8 | Per-channel rising-edge strobe |

## Verification
A write takes effect at the clock edge where it is sampled. The channel's accumulator moves for the first time one edge later, so the first level change comes ceil(d/64) edges after the enabling write. Read data appears one edge after the address and reflects every write from earlier edges. The bench drives inputs on the falling edge and samples on the next falling edge. Each result is therefore compared exactly one edge after the cause that the requirement counts from. An edge-accurate model is stepped on the same rising edges and compares all eight channels and the read data on every cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CH_COUNT   = 8;
  localparam int DIV_BITS   = 18;
  localparam int REG_BITS   = 32;
  localparam int BYTE_ADDR  = 6;
  localparam int ACC_STEP   = 64;
  localparam int MASTER_POS = 31;
  localparam int unsigned DIV_INIT = 32'h0003_FFC0;
endpackage

// File: rtl/fcd_regfile.sv
module fcd_regfile
  import fcd_pkg::*;
#(
  parameter int NCH        = CH_COUNT,
  parameter int DIV_W      = DIV_BITS,
  parameter int ADDR_W     = BYTE_ADDR,
  parameter int DATA_W     = REG_BITS,
  parameter int MBIT       = MASTER_POS,
  parameter int unsigned RST_DIV = DIV_INIT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    we,
  output logic [DATA_W-1:0]       rdata,
  output logic [NCH*DIV_W-1:0]    div_flat,
  output logic [NCH-1:0]          chan_en,
  output logic                    master_en
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int CFG_WORD = NCH;

  logic [WORD_W-1:0]            word;
  logic [NCH-1:0][DIV_W-1:0]    div_q;
  logic [NCH-1:0]               en_q;
  logic                         master_q;
  logic [DATA_W-1:0]            rd_next;
  logic                         unused_bits;

  assign word        = addr[ADDR_W-1:2];
  assign unused_bits = ^{addr[1:0], wdata[MBIT-1:DIV_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) div_q[i] <= DIV_W'(RST_DIV);
    end else if (we) begin
      for (int i = 0; i < NCH; i++)
        if (word == WORD_W'(i)) div_q[i] <= wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else if (we && word == WORD_W'(CFG_WORD)) begin
      en_q     <= wdata[NCH-1:0];
      master_q <= wdata[MBIT];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++)
      if (word == WORD_W'(i)) rd_next[DIV_W-1:0] = div_q[i];
    if (word == WORD_W'(CFG_WORD)) begin
      rd_next[NCH-1:0] = en_q;
      rd_next[MBIT]    = master_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_flat
      assign div_flat[g*DIV_W +: DIV_W] = div_q[g];
    end
  endgenerate

  assign chan_en   = en_q;
  assign master_en = master_q;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(word) > WORD_W'(CFG_WORD)) |-> (rdata == '0)); // R2
  AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we) && $past(word) == WORD_W'(CFG_WORD)) |-> (master_en == $past(wdata[MBIT]))); // R5
endmodule

// File: rtl/fcd_channel.sv
module fcd_channel
  import fcd_pkg::*;
#(
  parameter int DIV_W  = DIV_BITS,
  parameter int STEP   = ACC_STEP,
  parameter int unsigned RST_DIV = DIV_INIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             phase_o,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [DIV_W-1:0] act_q;
  logic             phase_q;
  logic             tick_q;
  logic [ACC_W-1:0] sum;
  logic             wrap;
  logic             bypass;

  assign sum    = acc_q + ACC_W'(STEP);
  assign wrap   = (sum >= {1'b0, act_q});
  assign bypass = (act_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      act_q   <= DIV_W'(RST_DIV);
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else if (!run) begin
      acc_q   <= '0;
      act_q   <= div_cfg;
      phase_q <= 1'b0;
      tick_q  <= 1'b0;
    end else if (bypass) begin
      acc_q   <= '0;
      act_q   <= div_cfg;
      phase_q <= ~phase_q;
      tick_q  <= 1'b1;
    end else if (wrap) begin
      acc_q   <= sum - {1'b0, act_q};
      act_q   <= div_cfg;
      phase_q <= ~phase_q;
      tick_q  <= ~phase_q;
    end else begin
      acc_q   <= sum;
      tick_q  <= 1'b0;
    end
  end

  assign phase_o = phase_q;
  assign tick_o  = tick_q;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!phase_q && !tick_q && acc_q == '0)); // R6
  AST_BYPASS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_q == '0) |=> tick_q); // R4
  AST_DIV_SWAP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(act_q) != '0 && act_q != $past(act_q)) |-> (phase_q != $past(phase_q))); // R7
  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && $past(run) && $past(act_q) != '0) |-> (phase_q && !$past(phase_q))); // R8
endmodule

// File: rtl/frac_clk_bank.sv
module frac_clk_bank
  import fcd_pkg::*;
#(
  parameter int NCH    = CH_COUNT,
  parameter int DIV_W  = DIV_BITS,
  parameter int ADDR_W = BYTE_ADDR,
  parameter int DATA_W = REG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    chan_phase,
  output logic [NCH-1:0]    chan_tick
);
  logic [NCH*DIV_W-1:0] div_flat;
  logic [NCH-1:0]       chan_en;
  logic                 master_en;

  fcd_regfile #(
    .NCH(NCH), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MBIT(DATA_W-1), .RST_DIV(DIV_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .div_flat(div_flat), .chan_en(chan_en), .master_en(master_en)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      fcd_channel #(.DIV_W(DIV_W), .STEP(ACC_STEP), .RST_DIV(DIV_INIT)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .run(master_en && chan_en[g]),
        .div_cfg(div_flat[g*DIV_W +: DIV_W]),
        .phase_o(chan_phase[g]),
        .tick_o(chan_tick[g])
      );
    end
  endgenerate

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (chan_phase == '0 && chan_tick == '0)); // R5
endmodule

// File: tb/frac_clk_bank_bench.sv
module frac_clk_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [7:0]  chan_phase, chan_tick;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_clk_bank u_frac_clk_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .chan_phase(chan_phase), .chan_tick(chan_tick)
  );

  // reference state, built from the requirements
  logic [17:0] m_div [NCH];
  logic [17:0] m_act [NCH];
  logic [18:0] m_acc [NCH];
  logic [7:0]  m_en;
  logic        m_mst;
  logic [7:0]  m_ph, m_tk;
  logic [31:0] m_rd;

  function automatic logic [31:0] mread(logic [5:0] a);
    logic [31:0] v = '0;
    int w = int'(a[5:2]);
    if (w < NCH) v[17:0] = m_div[w];
    else if (w == NCH) begin v[7:0] = m_en; v[31] = m_mst; end
    return v;
  endfunction

  function automatic string tag_of(int ch);
    if (!(m_mst && m_en[ch])) return "R5";
    if (m_act[ch] == '0) return "R4";
    if (m_act[ch] != m_div[ch]) return "R7";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_div[c] = 18'h3FFC0; m_act[c] = 18'h3FFC0; m_acc[c] = '0;
      end
      m_en = '0; m_mst = 1'b0; m_ph = '0; m_tk = '0; m_rd = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic [18:0] s;
        s = m_acc[c] + 19'd64;
        if (!(m_mst && m_en[c])) begin
          m_acc[c] = '0; m_act[c] = m_div[c]; m_ph[c] = 1'b0; m_tk[c] = 1'b0;
        end else if (m_act[c] == '0) begin
          m_acc[c] = '0; m_act[c] = m_div[c]; m_ph[c] = ~m_ph[c]; m_tk[c] = 1'b1;
        end else if (s >= {1'b0, m_act[c]}) begin
          m_acc[c] = s - {1'b0, m_act[c]}; m_act[c] = m_div[c];
          m_tk[c] = ~m_ph[c]; m_ph[c] = ~m_ph[c];
        end else begin
          m_acc[c] = s; m_tk[c] = 1'b0;
        end
      end
      m_rd = mread(reg_addr);
      if (reg_we) begin
        if (int'(reg_addr[5:2]) < NCH) m_div[reg_addr[5:2]] = reg_wdata[17:0];
        else if (int'(reg_addr[5:2]) == NCH) begin
          m_en = reg_wdata[7:0]; m_mst = reg_wdata[31];
        end
      end
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        chk(chan_phase[c] == m_ph[c], tag_of(c), chan_phase[c], m_ph[c]);
        chk(chan_tick[c] == m_tk[c], "R8", chan_tick[c], m_tk[c]);
      end
      chk(reg_rdata == m_rd, "R2", reg_rdata, m_rd);
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int seed_dummy;
    int toggles;
    logic prev;
    seed_dummy = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R1 and R2
    chk(chan_phase == 8'h00, "R5", chan_phase, 0);
    for (int c = 0; c < NCH; c++) rd(6'(c*4 + (c % 4 == 1 ? 1 : 0)), 32'h0003_FFC0, "R1");
    rd(6'h20, 32'h0, "R2");
    wr(6'h20, 32'hFFFF_FF5A);
    rd(6'h20, 32'h8000_005A, "R2");
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, 32'h0, "R2");
    rd(6'h20, 32'h8000_005A, "R2");
    wr(6'h20, 32'h0000_0000);
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h0C, 32'h0003_FFFF, "R2");
    cmp_on = 1'b1;
    // R5: channel bit without master stays quiet
    wr(6'h04, 32'd64);
    wr(6'h20, 32'h0000_0002);
    repeat (5) @(negedge clk);
    chk(chan_phase[1] == 1'b0, "R5", chan_phase[1], 0);
    // R3: exact count over 500 cycles with d = 100
    wr(6'h00, 32'd100);
    wr(6'h20, 32'h8000_0001);
    toggles = 0; prev = chan_phase[0];
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (chan_phase[0] != prev) toggles++;
      prev = chan_phase[0];
    end
    chk(toggles == 320, "R3", toggles, 320);
    // R6: first change ceil(200/64)=4 cycles after enabling write
    wr(6'h20, 32'h0);
    wr(6'h08, 32'd200);
    wr(6'h20, 32'h8000_0004);
    repeat (3) @(negedge clk);
    chk(chan_phase[2] == 1'b0, "R6", chan_phase[2], 0);
    @(negedge clk);
    chk(chan_phase[2] == 1'b1, "R6", chan_phase[2], 1);
    // R4: pass-through
    wr(6'h14, 32'd0);
    wr(6'h20, 32'h8000_0020);
    repeat (2) @(negedge clk);
    chk(chan_tick[5] == 1'b1, "R4", chan_tick[5], 1);
    // R7: retune while running
    wr(6'h18, 32'd640);
    wr(6'h20, 32'h8000_0040);
    repeat (13) @(negedge clk);
    wr(6'h18, 32'd128);
    repeat (40) @(negedge clk);
    // random mix
    for (int it = 0; it < 2500; it++) begin
      int r = $urandom % 10;
      if (r < 4) begin
        int k = $urandom % 8;
        logic [31:0] v;
        v = (k == 0) ? 32'd0 : (k == 1) ? 32'd64 : (k == 2) ? 32'h3FFC0 : 32'(64 + $urandom % 2000);
        wr(6'(($urandom % 8) * 4), v);
      end else if (r < 6) begin
        wr(6'h20, {($urandom % 4 != 0), 23'($urandom), 8'($urandom)});
      end else if (r == 6) begin
        wr(6'(36 + ($urandom % 7) * 4), $urandom);
      end else begin
        reg_addr = 6'($urandom);
        @(negedge clk);
      end
      repeat ($urandom % 6) @(negedge clk);
    end
    cmp_on = 1'b0;
    finish_run();
  end
endmodule